// File: doc/BRIEF.md
# Sequential Shift-Add Integer Multiplier

This block multiplies two `WIDTH`-bit integers over `WIDTH` clock cycles, one multiplier bit per cycle. A one-cycle start request, accepted only while the block is idle, captures the multiplicand, the multiplier and a mode bit that selects unsigned or two's-complement operation. The result appears as a high word and a low word, and a one-cycle done pulse marks it as final.

The datapath has a single `WIDTH+1`-bit adder and two `WIDTH`-bit registers. The upper register holds the running partial product. The lower register starts out holding the multiplier: each cycle one multiplier bit is used up from the bottom and one finished product bit enters at the top. Each cycle the multiplicand is added to the upper half when the current multiplier bit is 1. The widened sum is then written back already shifted right by one bit, so adding and shifting take one cycle together.

In two's-complement mode the multiplier's sign bit has negative weight. The step that uses it therefore subtracts the multiplicand. Both operands are sign-extended into the widened adder, so the sign of the sum is correct and is shifted into the top of the partial product. In unsigned mode the extension bits are zero and the adder carry becomes the new top bit.

Top module: `seq_mult`

## Requirements
- R1: While `rst_n` is low, and after it is released with no start, `busy_o` and `done_o` are 0 and `prod_hi_o` and `prod_lo_o` are all zeros.
- R2: A start (`start_i`=1 at a rising edge while `busy_o`=0) makes `busy_o` 1 from that edge onward. `done_o` is 1 in exactly the cycle that follows the `WIDTH`-th rising edge after the capturing edge, and `busy_o` falls at the same edge.
- R3: With `mode_i`=0 (unsigned), `{prod_hi_o, prod_lo_o}` during the done cycle equals the unsigned `2*WIDTH`-bit product of `mcand_i` and `mplier_i`.
- R4: With `mode_i`=1 (two's complement), `{prod_hi_o, prod_lo_o}` during the done cycle equals the two's-complement `2*WIDTH`-bit product of the operands.
- R5: In signed mode, the most negative value times itself gives +2^(2*WIDTH-2), and times -1 gives +2^(WIDTH-1). A negative multiplicand with any multiplier gives the correct result.
- R6: A `start_i` pulse while `busy_o`=1 is ignored: the running product completes with the operands and mode of the accepted start, and no extra done pulse follows.
- R7: `done_o` is high for exactly one cycle per accepted start and is never high while `busy_o` is high.
- R8: When the true product fits in `WIDTH` bits, `prod_hi_o` is all zeros in unsigned mode. In signed mode it is all copies of `prod_lo_o[WIDTH-1]`.
- R9: After the done cycle, `prod_hi_o` and `prod_lo_o` keep their values until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, sampled while idle |
| mode_i | input | 1 | 0 = unsigned, 1 = two's complement |
| mcand_i | input | WIDTH | Multiplicand |
| mplier_i | input | WIDTH | Multiplier |
| busy_o | output | 1 | Multiplication in progress |
| done_o | output | 1 | One-cycle result-valid pulse |
| prod_hi_o | output | WIDTH | Upper half of the product |
| prod_lo_o | output | WIDTH | Lower half of the product |

## Verification
The assertions assume that `start_i` is a clean synchronous level. They also assume that the operands and mode matter only at the edge where the start is accepted, so they place no rule on those inputs at other times. The stimulus changes inputs only on falling edges and keeps `start_i` high for a single cycle when it requests a multiplication. It also deliberately raises `start_i` in the middle of a run with different operands, which checks that the held state is guarded. Operands are random values plus the all-zeros, all-ones, most-negative and minus-one patterns, in both modes.

// File: rtl/seq_mult_pkg.sv
package seq_mult_pkg;
    typedef enum logic {
        MODE_UNSIGNED = 1'b0,
        MODE_SIGNED   = 1'b1
    } mult_mode_e;
endpackage

// File: rtl/seq_mult_ctl.sv
module seq_mult_ctl #(
    parameter int WIDTH = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic accept_i,
    output logic busy_o,
    output logic last_o,
    output logic done_o
);
    localparam int CW = (WIDTH > 1) ? $clog2(WIDTH) : 1;
    localparam logic [CW-1:0] LAST_CNT = CW'(WIDTH - 1);

    typedef struct packed {
        logic          busy;
        logic          done;
        logic [CW-1:0] cnt;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        if (accept_i) begin
            ctl_d.busy = 1'b1;
            ctl_d.cnt  = '0;
        end else if (ctl_q.busy) begin
            if (ctl_q.cnt == LAST_CNT) begin
                ctl_d.busy = 1'b0;
                ctl_d.done = 1'b1;
            end else begin
                ctl_d.cnt = ctl_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign busy_o = ctl_q.busy;
    assign done_o = ctl_q.done;
    assign last_o = ctl_q.busy && (ctl_q.cnt == LAST_CNT);

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R7
    AST_DONE_ENDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && $past(busy_o))); // R2
    AST_RUN_CONTINUES: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !last_o) |=> busy_o); // R2
endmodule

// File: rtl/seq_mult_step.sv
module seq_mult_step #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] hi_i,
    input  logic [WIDTH-1:0] lo_i,
    input  logic [WIDTH-1:0] mcand_i,
    input  logic             signed_mode_i,
    input  logic             last_i,
    output logic [WIDTH-1:0] hi_o,
    output logic [WIDTH-1:0] lo_o
);
    logic [WIDTH:0] ext_hi, ext_x, addend, sum;

    always_comb begin
        ext_hi = {signed_mode_i & hi_i[WIDTH-1], hi_i};
        ext_x  = {signed_mode_i & mcand_i[WIDTH-1], mcand_i};
        if (!lo_i[0])                    addend = '0;
        else if (signed_mode_i && last_i) addend = (WIDTH+1)'(0) - ext_x;
        else                              addend = ext_x;
        sum  = ext_hi + addend;
        hi_o = sum[WIDTH:1];
        lo_o = {sum[0], lo_i[WIDTH-1:1]};
    end
endmodule

// File: rtl/seq_mult.sv
module seq_mult #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             mode_i,
    input  logic [WIDTH-1:0] mcand_i,
    input  logic [WIDTH-1:0] mplier_i,
    output logic             busy_o,
    output logic             done_o,
    output logic [WIDTH-1:0] prod_hi_o,
    output logic [WIDTH-1:0] prod_lo_o
);
    import seq_mult_pkg::*;

    typedef struct packed {
        logic [WIDTH-1:0] hi;
        logic [WIDTH-1:0] lo;
        logic [WIDTH-1:0] x;
        mult_mode_e       mode;
    } dp_t;

    dp_t dp_d, dp_q;
    logic accept, last, busy, done;
    logic [WIDTH-1:0] step_hi, step_lo;

    assign accept = start_i && !busy;

    seq_mult_ctl #(.WIDTH(WIDTH)) u_ctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept_i (accept),
        .busy_o   (busy),
        .last_o   (last),
        .done_o   (done)
    );

    seq_mult_step #(.WIDTH(WIDTH)) u_step (
        .hi_i          (dp_q.hi),
        .lo_i          (dp_q.lo),
        .mcand_i       (dp_q.x),
        .signed_mode_i (dp_q.mode == MODE_SIGNED),
        .last_i        (last),
        .hi_o          (step_hi),
        .lo_o          (step_lo)
    );

    always_comb begin
        dp_d = dp_q;
        if (accept) begin
            dp_d.hi   = '0;
            dp_d.lo   = mplier_i;
            dp_d.x    = mcand_i;
            dp_d.mode = mult_mode_e'(mode_i);
        end else if (busy) begin
            dp_d.hi = step_hi;
            dp_d.lo = step_lo;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dp_q <= '{hi: '0, lo: '0, x: '0, mode: MODE_UNSIGNED};
        else        dp_q <= dp_d;
    end

    assign busy_o    = busy;
    assign done_o    = done;
    assign prod_hi_o = dp_q.hi;
    assign prod_lo_o = dp_q.lo;

    AST_LOAD_CLEARS_HI: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (prod_hi_o == '0 && prod_lo_o == $past(mplier_i) && busy_o)); // R2
    AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> ($stable(dp_q.x) && $stable(dp_q.mode))); // R6
    AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> ($stable(prod_hi_o) && $stable(prod_lo_o))); // R9
    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && busy_o)); // R7
endmodule

// File: tb/tb_seq_mult.sv
module tb_seq_mult;
    localparam int W = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic mode_i = 1'b0;
    logic [W-1:0] mcand_i = '0, mplier_i = '0;
    logic busy_o, done_o;
    logic [W-1:0] prod_hi_o, prod_lo_o;

    seq_mult #(.WIDTH(W)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
        .mcand_i(mcand_i), .mplier_i(mplier_i), .busy_o(busy_o),
        .done_o(done_o), .prod_hi_o(prod_hi_o), .prod_lo_o(prod_lo_o)
    );

    always #10 clk = ~clk; // 50 MHz

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    logic [2*W-1:0] exp_q[$];
    int exp_cyc_q[$];
    logic prev_done = 1'b0;
    logic [2*W-1:0] last_prod = '0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input logic [2*W-1:0] act,
                         input logic [2*W-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // monitor: pops expected results when done pulses
    always @(negedge clk) begin
        if (rst_n) begin
            if (done_o) begin
                check(!prev_done, "R7 single-cycle done", {15'd0, prev_done}, '0);
                check(!busy_o, "R7 busy low at done", {15'd0, busy_o}, '0);
                if (exp_q.size() == 0) begin
                    check(1'b0, "R6 unexpected done", {prod_hi_o, prod_lo_o}, '0);
                end else begin
                    logic [2*W-1:0] e;
                    int ec;
                    e  = exp_q.pop_front();
                    ec = exp_cyc_q.pop_front();
                    check({prod_hi_o, prod_lo_o} == e, "R3/R4/R5 product",
                          {prod_hi_o, prod_lo_o}, e);
                    check(cyc == ec, "R2 latency", (2*W)'(cyc), (2*W)'(ec));
                    last_prod = {prod_hi_o, prod_lo_o};
                end
            end
            prev_done = done_o;
        end
    end

    function automatic logic [2*W-1:0] ref_prod(input logic [W-1:0] a,
            input logic [W-1:0] b, input logic s);
        logic [2*W-1:0] ea, eb;
        ea = s ? {{W{a[W-1]}}, a} : {{W{1'b0}}, a};
        eb = s ? {{W{b[W-1]}}, b} : {{W{1'b0}}, b};
        return ea * eb;
    endfunction

    // driver: starts one multiplication and waits for its result
    task automatic run_op(input logic [W-1:0] a, input logic [W-1:0] b, input logic s,
                          input bit poke_busy);
        @(negedge clk);
        start_i = 1'b1; mode_i = s; mcand_i = a; mplier_i = b;
        @(negedge clk);
        start_i = 1'b0;
        exp_q.push_back(ref_prod(a, b, s));
        exp_cyc_q.push_back(cyc + W);
        check(busy_o == 1'b1, "R2 busy after start", {15'd0, busy_o}, 1);
        if (poke_busy) begin
            // R6: a second request mid-run with other operands
            @(negedge clk);
            start_i = 1'b1; mode_i = ~s; mcand_i = ~a; mplier_i = b + 8'd3;
            @(negedge clk);
            start_i = 1'b0;
        end
        while (exp_q.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        // R1 reset state
        repeat (3) @(negedge clk);
        check({busy_o, done_o} == 2'b00, "R1 flags in reset", {14'd0, busy_o, done_o}, 0);
        check({prod_hi_o, prod_lo_o} == 0, "R1 product in reset", {prod_hi_o, prod_lo_o}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check({busy_o, done_o} == 2'b00, "R1 idle after reset", {14'd0, busy_o, done_o}, 0);
        check({prod_hi_o, prod_lo_o} == 0, "R1 product after reset", {prod_hi_o, prod_lo_o}, 0);

        // R3 unsigned corners
        run_op(8'hFF, 8'hFF, 1'b0, 1'b0);
        run_op(8'h00, 8'hA5, 1'b0, 1'b0);
        run_op(8'h80, 8'h02, 1'b0, 1'b0);
        // R4 / R5 signed corners
        run_op(8'h80, 8'h80, 1'b1, 1'b0);
        run_op(8'h80, 8'hFF, 1'b1, 1'b0);
        run_op(8'hFF, 8'h80, 1'b1, 1'b0);
        run_op(8'hFF, 8'hFF, 1'b1, 1'b0);
        run_op(8'h85, 8'h13, 1'b1, 1'b0);
        run_op(8'h7F, 8'h7F, 1'b1, 1'b0);

        // R8 small products: high word is an extension of the low word
        run_op(8'h05, 8'h07, 1'b0, 1'b0);
        check(last_prod[15:8] == 8'h00, "R8 unsigned hi zero", last_prod, 16'h0023);
        run_op(8'hFD, 8'h04, 1'b1, 1'b0);
        check(last_prod[15:8] == {8{last_prod[7]}}, "R8 signed hi extension",
              last_prod, 16'hFFF4);

        // R6 start while busy
        run_op(8'h3C, 8'h9A, 1'b0, 1'b1);
        run_op(8'hC4, 8'h9A, 1'b1, 1'b1);

        // R9 hold after done
        repeat (4) @(negedge clk);
        check({prod_hi_o, prod_lo_o} == last_prod, "R9 hold", {prod_hi_o, prod_lo_o},
              last_prod);

        // R3 / R4 random
        for (int i = 0; i < 40; i++) begin
            run_op(W'($urandom), W'($urandom), 1'(i % 2), 1'b0);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule